// File: doc/BRIEF.md
# 625-Line Vertical Line Skipper

This block decides, one video line at a time, whether the timing generator should drop the current line. Dropping lines lets a 625-line picture fit a display panel whose row count suits a 525-line picture. For each line the block receives a line-start strobe, the line number within the frame, the field parity and the standard select. It returns a registered skip flag, which the timing generator reads for the rest of that line.

In 525-line operation the flag stays low. In 625-line operation the block removes two of every twelve lines, and the phase of that cadence differs between the two fields. A twelve-step phase counter restarts on each field's start line (line 22 for the odd field, line 334 for the even field), and a small per-field table of phases picks which lines to drop. The standard select is captured only on a field's start line. The decision for a whole field therefore rests on one consistent setting.

Top module: `line_skipper`

## Requirements
- R1: While reset is high, the skip flag is driven low on the next clock edge and stays low.
- R2: When the standard select captured at the current field's start line is low (525 lines), the skip flag is never raised.
- R3: In the odd field (field parity input high) with the 625-line setting captured, lines 22+12N+6 and 22+12N+12 for N = 0, 1, 2, ... are flagged (28, 34, 40, 46, ...), and no other line is.
- R4: In the even field (field parity input low) with the 625-line setting captured, lines 334+12N+3 and 334+12N+9 are flagged (337, 343, 349, ...), and no other line is.
- R5: A line whose number is below the start line of its field (22 odd, 334 even) is never flagged, and neither is the start line itself.
- R6: The flag takes its new value on the clock edge that samples the line-start strobe and holds that value until the next strobe.
- R7: The standard select is sampled only on the strobe of a field's start line, so a change in the middle of a field affects only the following field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate logic clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe marking the first cycle of a line |
| line_num | input | 10 | Line number within the frame, valid with the strobe |
| field_odd | input | 1 | Field parity: 1 for the odd field, 0 for the even field |
| std_625 | input | 1 | Standard select: 1 for 625-line, 0 for 525-line |
| skip_line | output | 1 | Registered per-line drop flag |

## Verification
If the phase counter is off by one step, every flagged line moves together by one position. The first wrong flag then appears on line 28 or line 337 of the first affected field, one clock after that line's strobe. If the captured standard or the active state is wrong, the error shows at the first cadence line of that field, or as a flag on a line that comes before the field's start line. The bench compares every line of several frames against an arithmetic model based on the line numbers. It also checks that the flag is unchanged at the end of each line. This covers constant 625-line frames, constant 525-line frames, a standard change in the middle of a field, random standard changes, and a reset in the middle of a field.

// File: rtl/lskip_pkg.sv
package lskip_pkg;

    // Lines per cadence period and the phase counter width derived from it.
    localparam int CADENCE = 12;
    localparam int PH_W    = $clog2(CADENCE);
    // Number of dropped lines per cadence period.
    localparam int SLOTS   = 2;

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic {
        FIELD_EVEN = 1'b0,
        FIELD_ODD  = 1'b1
    } field_e;

    // Per-line context seen by the decoder for the line being strobed.
    typedef struct packed {
        field_e field;
        logic   active;   // field start line seen and still in this field
        logic   first;    // this line is the field start line
        logic   std625;   // standard captured at field start
    } line_ctx_t;

    // Cadence phases (offset from the field start line, modulo CADENCE)
    // that are dropped, per field and slot.
    function automatic phase_t drop_phase(field_e f, int slot);
        phase_t p;
        if (f == FIELD_ODD) begin
            p = (slot == 0) ? phase_t'(6) : phase_t'(0);
        end else begin
            p = (slot == 0) ? phase_t'(3) : phase_t'(9);
        end
        return p;
    endfunction

    // Next phase with wrap at the end of the cadence.
    function automatic phase_t phase_step(phase_t p);
        return (p == phase_t'(CADENCE - 1)) ? '0 : phase_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/lskip_field_track.sv
module lskip_field_track
    import lskip_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int ODD_START  = 22,
    parameter int EVEN_START = 334
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic              std_625,
    output line_ctx_t         ctx
);

    localparam logic [LINE_W-1:0] ODD_L  = LINE_W'(ODD_START);
    localparam logic [LINE_W-1:0] EVEN_L = LINE_W'(EVEN_START);

    line_ctx_t         st_q;
    line_ctx_t         st_d;
    field_e            fld_in;
    logic [LINE_W-1:0] start_l;
    logic              at_start;
    logic              before_start;
    logic              parity_flip;

    always_comb begin
        fld_in       = field_e'(field_odd);
        start_l      = field_odd ? ODD_L : EVEN_L;
        at_start     = (line_num == start_l);
        before_start = (line_num < start_l);
        parity_flip  = (fld_in != st_q.field);
    end

    // Context for the line now being strobed.
    always_comb begin
        st_d       = st_q;
        st_d.first = 1'b0;
        if (at_start) begin
            st_d.field  = fld_in;
            st_d.active = 1'b1;
            st_d.first  = 1'b1;
            st_d.std625 = std_625;
        end else if (before_start || parity_flip) begin
            st_d.field  = fld_in;
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{field: FIELD_EVEN, active: 1'b0, first: 1'b0, std625: 1'b0};
        end else if (line_start) begin
            st_q <= st_d;
        end
    end

    assign ctx = st_d;

endmodule

// File: rtl/lskip_phase_ctr.sv
module lskip_phase_ctr
    import lskip_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_start,
    input  line_ctx_t ctx,
    output phase_t    phase
);

    phase_t phase_q;

    // Phase of the line being strobed: zero on the field start line.
    always_comb begin
        phase = ctx.first ? '0 : phase_step(phase_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (line_start) begin
            phase_q <= phase;
        end
    end

endmodule

// File: rtl/lskip_decode.sv
module lskip_decode
    import lskip_pkg::*;
(
    input  line_ctx_t ctx,
    input  phase_t    phase,
    output logic      drop
);

    logic [SLOTS-1:0] hit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign hit[s] = (phase == drop_phase(ctx.field, s));
    end

    // The start line shares phase zero but is never dropped.
    assign drop = ctx.active && ctx.std625 && !ctx.first && (|hit);

endmodule

// File: rtl/line_skipper.sv
module line_skipper
    import lskip_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int ODD_START  = 22,
    parameter int EVEN_START = 334
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic              std_625,
    output logic              skip_line
);

    line_ctx_t ctx;
    phase_t    phase;
    logic      drop;
    logic      skip_q;

    lskip_field_track #(
        .LINE_W    (LINE_W),
        .ODD_START (ODD_START),
        .EVEN_START(EVEN_START)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .line_num  (line_num),
        .field_odd (field_odd),
        .std_625   (std_625),
        .ctx       (ctx)
    );

    lskip_phase_ctr u_phase (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .ctx       (ctx),
        .phase     (phase)
    );

    lskip_decode u_dec (
        .ctx  (ctx),
        .phase(phase),
        .drop (drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q <= 1'b0;
        end else if (line_start) begin
            skip_q <= drop;
        end
    end

    assign skip_line = skip_q;

endmodule

// File: rtl/lskip_chk.sv
module lskip_chk #(
    parameter int LINE_W     = 10,
    parameter int ODD_START  = 22,
    parameter int EVEN_START = 334
) (
    input logic              clk,
    input logic              rst,
    input logic              line_start,
    input logic [LINE_W-1:0] line_num,
    input logic              field_odd,
    input logic              std_625,
    input logic              skip_line
);

    logic [LINE_W-1:0] start_l;
    logic              at_start;
    logic              before_start;
    logic              held_std;
    logic              eff_std;

    always_comb begin
        start_l      = field_odd ? LINE_W'(ODD_START) : LINE_W'(EVEN_START);
        at_start     = (line_num == start_l);
        before_start = (line_num < start_l);
        eff_std      = at_start ? std_625 : held_std;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_std <= 1'b0;
        end else if (line_start && at_start) begin
            held_std <= std_625;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !skip_line);

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> $stable(skip_line));

    // R5
    pre_start_chk: assert property (@(posedge clk) disable iff (rst)
        line_start && before_start |=> !skip_line);

    // R5
    start_line_chk: assert property (@(posedge clk) disable iff (rst)
        line_start && at_start |=> !skip_line);

    // R2
    std525_chk: assert property (@(posedge clk) disable iff (rst)
        line_start && !eff_std |=> !skip_line);

    // R3
    no_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        line_start && skip_line |=> !skip_line);

endmodule

bind line_skipper lskip_chk #(
    .LINE_W    (LINE_W),
    .ODD_START (ODD_START),
    .EVEN_START(EVEN_START)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .line_num  (line_num),
    .field_odd (field_odd),
    .std_625   (std_625),
    .skip_line (skip_line)
);

// File: tb/line_skipper_bench.sv
module line_skipper_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 10;
    localparam int FRAME      = 625;
    localparam int ODD_LAST   = 312;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              line_start = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic              field_odd = 1'b1;
    logic              std_625 = 1'b0;
    logic              skip_line;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    // Bench model state
    bit  m_std    = 1'b0;
    bit  m_active = 1'b0;
    bit  m_odd    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_skipper #(.LINE_W(LINE_W)) u_line_skipper (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .line_num  (line_num),
        .field_odd (field_odd),
        .std_625   (std_625),
        .skip_line (skip_line)
    );

    function automatic bit cadence_hit(int ln, bit odd);
        if (odd) return (ln >= 28) && (((ln - 22) % 12 == 6) || ((ln - 22) % 12 == 0));
        return (ln >= 337) && (((ln - 334) % 12 == 3) || ((ln - 334) % 12 == 9));
    endfunction

    task automatic check(string req, logic act, logic exp, int ln);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s line %0d: skip_line=%b expected %b", req, ln, act, exp);
        end
    endtask

    // Drive one line, update the model, check after the strobe and at line end.
    task automatic run_line(int ln, bit odd, bit s, string tag);
        int  st;
        bit  exp;
        string req;
        st = odd ? 22 : 334;
        if (ln == st) begin
            m_active = 1'b1; m_std = s; m_odd = odd;
        end else if (ln < st || odd != m_odd) begin
            m_active = 1'b0; m_odd = odd;
        end
        exp = m_active && m_std && cadence_hit(ln, odd);
        if (tag != "") req = tag;
        else if (ln <= st) req = "R5";
        else if (!m_std) req = "R2";
        else req = odd ? "R3" : "R4";
        @(negedge clk);
        line_start = 1'b1;
        line_num   = LINE_W'(ln);
        field_odd  = odd;
        std_625    = s;
        @(negedge clk);
        line_start = 1'b0;
        check(req, skip_line, exp, ln);
        for (int k = 0; k < int'($urandom_range(3, 0)); k++) @(negedge clk);
        // R6: value unchanged through the rest of the line
        check("R6", skip_line, exp, ln);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5417));
        repeat (3) @(negedge clk);
        check("R1", skip_line, 1'b0, 0);
        rst = 1'b0;

        // Frame mode 0: 625 throughout, with a reset inside the odd field.
        for (int ln = 1; ln <= FRAME; ln++) begin
            run_line(ln, ln <= ODD_LAST, 1'b1, "");
            if (ln == 28) begin
                // R1: reset while the flag is high clears it
                @(negedge clk);
                rst = 1'b1;
                @(negedge clk);
                check("R1", skip_line, 1'b0, ln);
                rst = 1'b0;
                m_active = 1'b0; m_std = 1'b0;
            end
        end
        // Frame mode 1: 525 at odd start, select raised mid-field (R7).
        for (int ln = 1; ln <= FRAME; ln++) begin
            bit odd = (ln <= ODD_LAST);
            run_line(ln, odd, ln >= 100, (odd && ln >= 100) ? "R7" : "");
        end
        // Frame mode 2: random select on every line (R7).
        for (int ln = 1; ln <= FRAME; ln++) begin
            run_line(ln, ln <= ODD_LAST, 1'($urandom_range(1, 0)), "R7");
        end
        // Frame mode 3: 525 throughout.
        for (int ln = 1; ln <= FRAME; ln++) begin
            run_line(ln, ln <= ODD_LAST, 1'b0, "R2");
        end
        // Frame mode 4: 625 throughout, clean.
        for (int ln = 1; ln <= FRAME; ln++) begin
            run_line(ln, ln <= ODD_LAST, 1'b1, "");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule